// File: doc/BRIEF.md
# Transmit stop and pause controller

This block decides when an Ethernet MAC transmitter may begin its next data frame. Three things can hold data frames. The first is a graceful stop set by software. The second is a software request to send a flow-control PAUSE frame, which clears itself once the frame is sent. The third is a timed hold that starts when the link partner sends a PAUSE frame. The block also asks the datapath to send the PAUSE frame. It raises a one-cycle interrupt when a stop takes effect, and it checks the collision input for a heartbeat after each frame ends.

The transmit datapath connects through a small set of signals. It raises `frame_pending_i` while a data frame waits at the head of its queue. It receives a one-cycle `data_start_o` grant. It reports the frame's end with `tx_done_i`, or an abort with `early_col_i`. While `pause_req_o` is high the datapath owns the line for one PAUSE frame and answers with `pause_done_i`. The block also holds the lower 32 bits of the station address, which the datapath places in the PAUSE frame's source address field.

Top module: `mac_tx_pause_ctrl`

## Requirements
- R1: `data_start_o` is high in a cycle exactly when `frame_pending_i` is high, no data frame is in flight, no PAUSE frame is requested, graceful stop is low, no received pause is active, and the line check passes. In half duplex the line check requires `carrier_i` and `collision_i` both low. A grant puts a frame in flight from the next cycle.
- R2: While graceful stop is high, no new data frame is granted, and a frame already in flight still completes. `stop_done_o` pulses in the second cycle after the `tx_done_i` cycle.
- R3: If graceful stop rises while nothing is in flight, `stop_done_o` pulses in the next cycle.
- R4: `stop_done_o` lasts one cycle and pulses at most once while the stop request stays continuously asserted.
- R5: Clearing graceful stop lets the waiting frame be granted in that same cycle.
- R6: `early_col_i` ends the frame in flight. With graceful stop high the frame is not granted again until graceful stop clears, and then it is granted again.
- R7: A `pause_set_i` pulse sets `tfc_pending_o` in the next cycle, and data grants stop. Once no data frame is in flight, `pause_req_o` and `stop_done_o` rise together one cycle later. `pause_req_o` stays high until `pause_done_i`, after which `tfc_pending_o` and `pause_req_o` are low and data grants resume.
- R8: A PAUSE frame is still requested while data frames are held by graceful stop or by a received pause.
- R9: When `full_duplex_i` is high, a `rx_pause_i` pulse with a non-zero quanta count Q raises `data_paused_o` from the next cycle for exactly Q×TICKS_PER_QUANTUM cycles, and data grants are blocked for that time. When `full_duplex_i` is low, `rx_pause_i` is ignored.
- R10: A received quanta count of zero clears `data_paused_o` in the next cycle. A new PAUSE frame received during a hold restarts the full duration.
- R11: With `full_duplex_i` high, `carrier_i` and `collision_i` do not affect grants.
- R12: On `tx_done_i`, `hb_error_o` clears. If `hb_enable_i` is high, the HB_WINDOW cycles that follow form a window, and `hb_error_o` is set after the window if `collision_i` was not seen in it.
- R13: `station_addr_o` takes the value of `station_addr_wdata_i` in the cycle after `station_addr_we_i`, and holds it otherwise. This register has no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| graceful_stop_i | input | 1 | Software graceful stop |
| pause_set_i | input | 1 | Pulse: request one PAUSE frame |
| full_duplex_i | input | 1 | Full-duplex mode |
| hb_enable_i | input | 1 | Heartbeat check enable |
| frame_pending_i | input | 1 | A data frame waits in the queue |
| tx_done_i | input | 1 | Pulse: data frame finished |
| early_col_i | input | 1 | Pulse: data frame aborted by early collision |
| carrier_i | input | 1 | Carrier sense |
| collision_i | input | 1 | Collision detect |
| pause_done_i | input | 1 | Pulse: PAUSE frame sent |
| rx_pause_i | input | 1 | Pulse: PAUSE frame received |
| rx_quanta_i | input | QW | Quanta count of the received PAUSE frame |
| station_addr_we_i | input | 1 | Station address write strobe |
| station_addr_wdata_i | input | 32 | Station address write data |
| data_start_o | output | 1 | Grant to start a data frame |
| pause_req_o | output | 1 | Send a PAUSE frame now |
| stop_done_o | output | 1 | Stop-complete interrupt pulse |
| tfc_pending_o | output | 1 | PAUSE send request outstanding |
| data_paused_o | output | 1 | Received-pause hold active |
| hb_error_o | output | 1 | Heartbeat missing after last frame |
| station_addr_o | output | 32 | Low 32 bits of the PAUSE source address |

## Verification
The bench drives every combination of pending frame, stop, duplex mode, carrier and collision. This would catch a grant that leaks through carrier or collision in full duplex, or one that ignores them in half duplex. It checks when the stop interrupt arrives, both with a frame in flight and with the line idle. An early pulse, a repeated pulse, or a pulse that never comes would each show up in the cycle-exact sample. It sweeps the pause quanta and the position of the heartbeat collision across the window edge, to expose off-by-one timers. It also checks that a zero count cancels a hold, that a new count reloads it, and that a PAUSE frame is still requested while data is held.

// File: rtl/mac_txp_pkg.sv
package mac_txp_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_DATA  = 2'd1,
    OWN_PAUSE = 2'd2
  } line_owner_e;
endpackage

// File: rtl/mac_txp_pause_timer.sv
module mac_txp_pause_timer #(
  parameter int QW    = 16,
  parameter int TICKS = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [QW-1:0] quanta_i,
  output logic          paused_o
);
  localparam int TW = $clog2(TICKS + 1);

  logic [TW-1:0] tick_q;
  logic [QW-1:0] quanta_q;
  logic          paused_q;
  logic          wrap;

  assign wrap = (tick_q == TW'(TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q   <= '0;
      quanta_q <= '0;
      paused_q <= 1'b0;
    end else if (load_i) begin
      tick_q   <= '0;
      quanta_q <= quanta_i;
      paused_q <= (quanta_i != '0);
    end else if (paused_q) begin
      if (wrap) begin
        tick_q   <= '0;
        quanta_q <= quanta_q - 1'b1;
        if (quanta_q == QW'(1)) paused_q <= 1'b0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign paused_o = paused_q;

  AST_PAUSE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && quanta_i != '0) |=> paused_o);  // R9
  AST_ZERO_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && quanta_i == '0) |=> !paused_o);  // R10
endmodule

// File: rtl/mac_txp_heartbeat.sv
module mac_txp_heartbeat #(
  parameter int WIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_done_i,
  input  logic hb_enable_i,
  input  logic collision_i,
  output logic hb_error_o
);
  localparam int WW = $clog2(WIN + 1);

  logic [WW-1:0] win_q;
  logic          seen_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (tx_done_i) begin
      win_q  <= hb_enable_i ? WW'(WIN) : '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
      if (collision_i) seen_q <= 1'b1;
      if (win_q == WW'(1) && !seen_q && !collision_i) err_q <= 1'b1;
    end
  end

  assign hb_error_o = err_q;

  AST_HB_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !hb_error_o);  // R12
endmodule

// File: rtl/mac_txp_seq.sv
module mac_txp_seq
  import mac_txp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic graceful_stop_i,
  input  logic pause_set_i,
  input  logic full_duplex_i,
  input  logic carrier_i,
  input  logic collision_i,
  input  logic frame_pending_i,
  input  logic tx_done_i,
  input  logic early_col_i,
  input  logic pause_done_i,
  input  logic rx_hold_i,
  output logic data_start_o,
  output logic pause_req_o,
  output logic stop_done_o,
  output logic tfc_pending_o
);
  line_owner_e owner_q, owner_d;
  logic tfc_q, gra_q, gra_done_q;
  logic line_ok, hold, start, pstart, stop_req, fire;

  always_comb begin
    line_ok  = full_duplex_i | (!carrier_i & !collision_i);
    hold     = graceful_stop_i | tfc_q | rx_hold_i;
    start    = (owner_q == OWN_IDLE) & frame_pending_i & !hold & line_ok;
    pstart   = (owner_q == OWN_IDLE) & tfc_q;
    stop_req = graceful_stop_i | tfc_q;
    fire     = stop_req & (owner_q != OWN_DATA) & !gra_done_q;
    owner_d  = owner_q;
    unique case (owner_q)
      OWN_IDLE:  if (pstart) owner_d = OWN_PAUSE;
                 else if (start) owner_d = OWN_DATA;
      OWN_DATA:  if (tx_done_i || early_col_i) owner_d = OWN_IDLE;
      OWN_PAUSE: if (pause_done_i) owner_d = OWN_IDLE;
      default:   owner_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q    <= OWN_IDLE;
      tfc_q      <= 1'b0;
      gra_q      <= 1'b0;
      gra_done_q <= 1'b0;
    end else begin
      owner_q <= owner_d;
      if (pause_set_i) tfc_q <= 1'b1;
      else if (owner_q == OWN_PAUSE && pause_done_i) tfc_q <= 1'b0;
      gra_q      <= fire;
      gra_done_q <= stop_req & (gra_done_q | fire);
    end
  end

  assign data_start_o  = start;
  assign pause_req_o   = (owner_q == OWN_PAUSE);
  assign stop_done_o   = gra_q;
  assign tfc_pending_o = tfc_q;

  AST_GRA_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_o |=> !stop_done_o);  // R4
  AST_PSEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && !pause_done_i) |=> pause_req_o);  // R7
  AST_TFC_SELFCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_req_o && pause_done_i && !pause_set_i) |=> !tfc_pending_o);  // R7
endmodule

// File: rtl/mac_tx_pause_ctrl.sv
module mac_tx_pause_ctrl #(
  parameter int QW                = 16,
  parameter int TICKS_PER_QUANTUM = 128,
  parameter int HB_WINDOW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          graceful_stop_i,
  input  logic          pause_set_i,
  input  logic          full_duplex_i,
  input  logic          hb_enable_i,
  input  logic          frame_pending_i,
  input  logic          tx_done_i,
  input  logic          early_col_i,
  input  logic          carrier_i,
  input  logic          collision_i,
  input  logic          pause_done_i,
  input  logic          rx_pause_i,
  input  logic [QW-1:0] rx_quanta_i,
  input  logic          station_addr_we_i,
  input  logic [31:0]   station_addr_wdata_i,
  output logic          data_start_o,
  output logic          pause_req_o,
  output logic          stop_done_o,
  output logic          tfc_pending_o,
  output logic          data_paused_o,
  output logic          hb_error_o,
  output logic [31:0]   station_addr_o
);
  logic rx_hold;
  logic [31:0] sa_q;

  mac_txp_pause_timer #(.QW(QW), .TICKS(TICKS_PER_QUANTUM)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (rx_pause_i & full_duplex_i),
    .quanta_i (rx_quanta_i),
    .paused_o (rx_hold)
  );

  mac_txp_seq u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .graceful_stop_i (graceful_stop_i),
    .pause_set_i     (pause_set_i),
    .full_duplex_i   (full_duplex_i),
    .carrier_i       (carrier_i),
    .collision_i     (collision_i),
    .frame_pending_i (frame_pending_i),
    .tx_done_i       (tx_done_i),
    .early_col_i     (early_col_i),
    .pause_done_i    (pause_done_i),
    .rx_hold_i       (rx_hold),
    .data_start_o    (data_start_o),
    .pause_req_o     (pause_req_o),
    .stop_done_o     (stop_done_o),
    .tfc_pending_o   (tfc_pending_o)
  );

  mac_txp_heartbeat #(.WIN(HB_WINDOW)) u_hb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_done_i   (tx_done_i),
    .hb_enable_i (hb_enable_i),
    .collision_i (collision_i),
    .hb_error_o  (hb_error_o)
  );

  // software-initialised, deliberately no reset
  always_ff @(posedge clk_i) begin
    if (station_addr_we_i) sa_q <= station_addr_wdata_i;
  end

  assign data_paused_o  = rx_hold;
  assign station_addr_o = sa_q;

  AST_HOLD_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_paused_o |-> !data_start_o);  // R9
endmodule

// File: tb/tb_mac_tx_pause_ctrl.sv
module tb_mac_tx_pause_ctrl;
  localparam int QW = 16;
  localparam int TQ = 3;
  localparam int HW = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gs = 0, tfc_set = 0, fd = 1, hbe = 0, pend = 0, txd = 0, ecol = 0;
  logic crs = 0, col = 0, pdone = 0, rxp = 0, sa_we = 0;
  logic [QW-1:0] quanta = '0;
  logic [31:0] sa_wd = '0;
  logic start, preq, sdone, tfcp, paused, hberr;
  logic [31:0] sa;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mac_tx_pause_ctrl #(.QW(QW), .TICKS_PER_QUANTUM(TQ), .HB_WINDOW(HW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .graceful_stop_i(gs), .pause_set_i(tfc_set),
    .full_duplex_i(fd), .hb_enable_i(hbe), .frame_pending_i(pend), .tx_done_i(txd),
    .early_col_i(ecol), .carrier_i(crs), .collision_i(col), .pause_done_i(pdone),
    .rx_pause_i(rxp), .rx_quanta_i(quanta), .station_addr_we_i(sa_we),
    .station_addr_wdata_i(sa_wd), .data_start_o(start), .pause_req_o(preq),
    .stop_done_o(sdone), .tfc_pending_o(tfcp), .data_paused_o(paused),
    .hb_error_o(hberr), .station_addr_o(sa)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic nc();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic finish_frame();
    nc(); pend = 0; txd = 1;
    nc(); txd = 0;
  endtask

  task automatic count_paused(output int n);
    n = 0;
    while (paused === 1'b1 && n < 200) begin
      n++;
      nc(); settle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    int cnt;
    repeat (3) nc();
    settle();
    chk("R4 reset stop_done", sdone, 0);
    chk("R7 reset pause_req", preq, 0);
    chk("R7 reset tfc_pending", tfcp, 0);
    chk("R9 reset paused", paused, 0);
    chk("R12 reset hb_error", hberr, 0);
    nc(); rst_ni = 1;
    nc();

    // R1 / R11: exhaustive grant sweep from idle
    for (int v = 0; v < 32; v++) begin
      nc();
      pend = v[0]; gs = v[1]; fd = v[2]; crs = v[3]; col = v[4];
      settle();
      chk(v[2] ? "R11 grant full duplex" : "R1 grant half duplex", start,
          32'(v[0] & !v[1] & (v[2] | (!v[3] & !v[4]))));
      pend = 0; gs = 0; crs = 0; col = 0; fd = 1;
    end

    // R3: stop while idle
    nc(); gs = 1; settle();
    nc(); settle(); chk("R3 idle stop pulse", sdone, 1);
    nc(); settle(); chk("R4 pulse length", sdone, 0);
    nc(); gs = 0;
    nc();

    // R2 / R4 / R5
    nc(); pend = 1; settle(); chk("R1 grant", start, 1);
    nc(); gs = 1; settle(); chk("R2 no grant in flight", start, 0);
    chk("R2 no pulse in flight", sdone, 0);
    for (int i = 0; i < 3; i++) begin nc(); settle(); chk("R2 wait in flight", sdone, 0); end
    nc(); txd = 1; settle(); chk("R2 pulse not early", sdone, 0);
    nc(); txd = 0; settle(); chk("R2 pulse not early", sdone, 0);
    chk("R2 stop blocks grant", start, 0);
    nc(); settle(); chk("R2 pulse after frame", sdone, 1);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin nc(); settle(); if (sdone) cnt++; end
    chk("R4 single pulse", cnt, 0);
    nc(); gs = 0; settle(); chk("R5 resume grant", start, 1);

    // R6: early collision while stopped
    nc(); gs = 1; ecol = 1;
    nc(); ecol = 0; settle(); chk("R6 held after collision", start, 0);
    for (int i = 0; i < 2; i++) begin nc(); settle(); chk("R6 held", start, 0); end
    nc(); gs = 0; settle(); chk("R6 retry after clear", start, 1);
    finish_frame();

    // R7: pause request during a frame
    nc(); pend = 1; settle(); chk("R1 grant", start, 1);
    nc(); pend = 0; tfc_set = 1;
    nc(); tfc_set = 0; settle();
    chk("R7 tfc pending set", tfcp, 1);
    chk("R7 waits for frame", preq, 0);
    nc(); settle(); chk("R7 waits for frame", preq, 0);
    nc(); txd = 1;
    nc(); txd = 0; pend = 1; settle();
    chk("R7 req not early", preq, 0);
    chk("R7 data blocked", start, 0);
    nc(); settle();
    chk("R7 pause req", preq, 1);
    chk("R7 stop pulse", sdone, 1);
    chk("R1 no grant during pause frame", start, 0);
    for (int i = 0; i < 3; i++) begin nc(); settle(); chk("R7 req held", preq, 1); end
    nc(); pdone = 1; settle(); chk("R7 no grant before done", start, 0);
    nc(); pdone = 0; settle();
    chk("R7 self clear", tfcp, 0);
    chk("R7 req drop", preq, 0);
    chk("R7 data resume", start, 1);
    finish_frame();

    // R8: pause frame while stopped
    nc(); gs = 1; tfc_set = 1;
    nc(); tfc_set = 0;
    nc(); settle(); chk("R8 pause under stop", preq, 1);
    nc(); pdone = 1;
    nc(); pdone = 0; settle(); chk("R8 req drop", preq, 0);
    chk("R8 tfc clear", tfcp, 0);
    nc(); gs = 0;

    // R8 under received pause, then R10 cancel
    nc(); rxp = 1; quanta = 20; tfc_set = 1;
    nc(); rxp = 0; tfc_set = 0; settle(); chk("R9 paused", paused, 1);
    nc(); settle(); chk("R8 pause under rx hold", preq, 1);
    nc(); pdone = 1;
    nc(); pdone = 0; settle(); chk("R9 still paused", paused, 1);
    nc(); rxp = 1; quanta = 0;
    nc(); rxp = 0; settle(); chk("R10 zero cancels", paused, 0);

    // R9: duration sweep
    for (int q = 1; q <= 6; q++) begin
      nc(); rxp = 1; quanta = QW'(q);
      nc(); rxp = 0; settle();
      count_paused(n);
      chk("R9 hold duration", n, q * TQ);
    end
    nc(); rxp = 1; quanta = 2;
    nc(); rxp = 0; pend = 1; settle(); chk("R9 grant blocked", start, 0);
    for (int i = 0; i < 5; i++) nc();
    nc(); settle(); chk("R9 grant after hold", start, 1);
    finish_frame();
    nc(); fd = 0; rxp = 1; quanta = 4;
    nc(); rxp = 0; settle(); chk("R9 ignored in half duplex", paused, 0);
    fd = 1;

    // R10: reload
    nc(); rxp = 1; quanta = 2;
    nc(); rxp = 0;
    nc();
    nc();
    nc(); rxp = 1; quanta = 2;
    nc(); rxp = 0; settle();
    count_paused(n);
    chk("R10 reload", n, 2 * TQ);

    // R12: heartbeat sweep of collision position
    for (int k = 1; k <= 6; k++) begin
      nc(); pend = 1;
      nc(); pend = 0; hbe = 1; txd = 1;
      for (int j = 1; j <= 6; j++) begin
        nc(); txd = 0; col = (j == k);
      end
      nc(); col = 0; settle();
      chk("R12 heartbeat window", hberr, 32'(k > HW));
    end
    nc(); pend = 1;
    nc(); pend = 0; hbe = 0; txd = 1;
    for (int j = 0; j < 6; j++) begin nc(); txd = 0; end
    settle(); chk("R12 disabled no error", hberr, 0);

    // R13: station address
    nc(); sa_we = 1; sa_wd = 32'hA1B2_C3D4;
    nc(); sa_we = 0; settle(); chk("R13 write", sa, 32'hA1B2_C3D4);
    nc(); sa_wd = 32'h0BAD_F00D;
    nc(); settle(); chk("R13 hold without strobe", sa, 32'hA1B2_C3D4);
    nc(); sa_we = 1; sa_wd = 32'h5E6F_7081;
    nc(); sa_we = 0; settle(); chk("R13 rewrite", sa, 32'h5E6F_7081);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule